// File: doc/BRIEF.md
# Bus Clock and Reset Sequencer

This block turns one of two free-running source clocks into a divide-by-four bus clock. It also produces two single-cycle clock enables, one for the processor core and one for the peripherals. Both source clocks arrive as ordinary digital inputs and are sampled by a fast sequencer clock, `sys_clk`. An edge detector on each source yields one tick per source period. A select input picks which source drives the bus divider.

The block also orders the release of clocks and reset. A power-on or low-voltage request holds the whole bus quiet. When the request ends, a single counter, always fed by oscillator ticks, times the startup delay while the external active-low reset stays driven. The same counter times the recovery delay after a low-power stop ends. A wait request gates only the core enable, so peripherals keep running. A stop request parks every bus clock until a wake-up interrupt arrives.

Top module: `bus_clk_rst_seq`

## Requirements
- R1: `bus_clk_o` is the selected source divided by four. It is low for two source ticks and high for two. Its period is 16 `sys_clk` cycles when the oscillator input toggles every two cycles (pll_sel_i=0), and 8 cycles when the PLL input toggles every cycle (pll_sel_i=1).
- R2: While `por_req_i` or `lvr_req_i` is high, `rst_out_n_o`, `bus_clk_o`, `cpu_ce_o` and `per_ce_o` are all low from the following `sys_clk` cycle onward.
- R3: After the reset request drops, `rst_out_n_o` rises exactly when the POR_CYCLES-th oscillator rising edge has been seen. The default is 4096. PLL edges do not count toward this delay.
- R4: A new power-on or low-voltage request in any state, including stop recovery or a running startup count, drives `rst_out_n_o` low again and restarts the full count from zero.
- R5: Once the clocks are released, the divider starts from phase zero, so `bus_clk_o` first rises on the second selected-source tick after release.
- R6: In run mode, `cpu_ce_o` and `per_ce_o` each pulse for one `sys_clk` cycle per bus cycle, in the cycle where `bus_clk_o` has just fallen.
- R7: A wait request is taken at a bus-cycle boundary. After that, `cpu_ce_o` stays low while `per_ce_o` and `bus_clk_o` continue.
- R8: A `wake_irq_i` pulse during wait returns the block to run mode, and `cpu_ce_o` pulses again at the next bus-cycle boundary.
- R9: A stop request is taken at a bus-cycle boundary. After that, `bus_clk_o`, `cpu_ce_o` and `per_ce_o` stay low and `rst_out_n_o` stays high.
- R10: A `wake_irq_i` pulse in stop starts a recovery of STOP_CYCLES oscillator rising edges (default 4096). `rst_out_n_o` stays high during it. The divider then restarts at phase zero, so `bus_clk_o` first rises on oscillator edge STOP_CYCLES+2.
- R11: A change of `pll_sel_i` takes effect only at the next bus-cycle boundary. With the oscillator changing every 2 cycles (rising edge when the bench's negedge count is 2 mod 4), switching to the PLL just after a rise gives one rise-to-rise interval of 11 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Sequencer sampling clock |
| osc_clk_i | input | 1 | Oscillator-derived source clock, sampled as data |
| pll_clk_i | input | 1 | PLL-derived source clock, sampled as data |
| pll_sel_i | input | 1 | Source select: 1 selects the PLL clock |
| por_req_i | input | 1 | Power-on reset request, active high |
| lvr_req_i | input | 1 | Low-voltage reset request, active high |
| stop_req_i | input | 1 | Stop mode request, level |
| wait_req_i | input | 1 | Wait mode request, level |
| wake_irq_i | input | 1 | Wake-up interrupt |
| bus_clk_o | output | 1 | Divide-by-four bus clock, parked low when inactive |
| cpu_ce_o | output | 1 | Core clock enable, one pulse per bus cycle |
| per_ce_o | output | 1 | Peripheral clock enable, one pulse per bus cycle |
| rst_out_n_o | output | 1 | Active-low external reset drive |

## Verification
The hardest situation to reach is a low-voltage reset that lands in the middle of stop recovery. Reaching it takes a stop entry, a wake, and then the reset while the shared counter is part way through. The bench gets there with a directed chain: stop, wake, wait 3000 cycles, then a low-voltage pulse. It then counts its own oscillator edges up to the reset release and the first bus rise. A second chain interrupts a running power-on count with a fresh request. Random select changes and wait episodes, drawn from a seeded generator, exercise the boundary-aligned switching and the gating.

// File: rtl/bus_clk_rst_seq.sv
module bus_clk_rst_seq #(
  parameter int POR_CYCLES  = 4096,
  parameter int STOP_CYCLES = 4096
) (
  input  logic sys_clk,
  input  logic osc_clk_i,
  input  logic pll_clk_i,
  input  logic pll_sel_i,
  input  logic por_req_i,
  input  logic lvr_req_i,
  input  logic stop_req_i,
  input  logic wait_req_i,
  input  logic wake_irq_i,
  output logic bus_clk_o,
  output logic cpu_ce_o,
  output logic per_ce_o,
  output logic rst_out_n_o
);

  localparam int LIM_MAX = (POR_CYCLES > STOP_CYCLES) ? POR_CYCLES : STOP_CYCLES;
  localparam int CW = $clog2(LIM_MAX + 1);
  localparam logic [CW-1:0] POR_LIM  = CW'(POR_CYCLES);
  localparam logic [CW-1:0] STOP_LIM = CW'(STOP_CYCLES);

  typedef enum logic [2:0] {S_POR, S_RUN, S_WAIT, S_STOP, S_WAKE} st_t;

  st_t st;
  logic osc_q, pll_q, sel_q;
  logic [1:0] phase;
  logic [CW-1:0] cnt;

  wire hard_rst   = por_req_i | lvr_req_i;
  wire osc_rise   = osc_clk_i & ~osc_q;
  wire pll_rise   = pll_clk_i & ~pll_q;
  wire src_tick   = sel_q ? pll_rise : osc_rise;
  wire clocks_on  = (st == S_RUN) || (st == S_WAIT);
  wire boundary   = clocks_on && src_tick && (phase == 2'd3);
  wire [CW-1:0] lim = (st == S_WAKE) ? STOP_LIM : POR_LIM;
  wire count_done = osc_rise && (cnt == lim - 1'b1);

  assign bus_clk_o   = phase[1];
  assign rst_out_n_o = (st != S_POR);

  always_ff @(posedge sys_clk) begin
    osc_q <= osc_clk_i;
    pll_q <= pll_clk_i;
  end

  always_ff @(posedge sys_clk) begin
    if (hard_rst) begin
      st       <= S_POR;
      cnt      <= '0;
      phase    <= '0;
      sel_q    <= pll_sel_i;
      cpu_ce_o <= 1'b0;
      per_ce_o <= 1'b0;
    end else begin
      cpu_ce_o <= boundary && (st == S_RUN);
      per_ce_o <= boundary;
      case (st)
        S_POR, S_WAKE: begin
          sel_q <= pll_sel_i;
          phase <= '0;
          if (osc_rise) cnt <= count_done ? '0 : cnt + 1'b1;
          if (count_done) st <= S_RUN;
        end
        S_STOP: begin
          sel_q <= pll_sel_i;
          phase <= '0;
          cnt   <= '0;
          if (wake_irq_i) st <= S_WAKE;
        end
        S_RUN: begin
          if (src_tick) phase <= phase + 2'd1;
          if (boundary) begin
            sel_q <= pll_sel_i;
            if (stop_req_i)      st <= S_STOP;
            else if (wait_req_i) st <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (src_tick) phase <= phase + 2'd1;
          if (boundary) sel_q <= pll_sel_i;
          if (wake_irq_i) st <= S_RUN;
        end
        default: st <= S_POR;
      endcase
    end
  end

  assert_reset_quiet_R2: assert property (@(posedge sys_clk)
    hard_rst |=> (!rst_out_n_o && !bus_clk_o && !cpu_ce_o && !per_ce_o));

  assert_release_on_osc_R3: assert property (@(posedge sys_clk) disable iff (hard_rst)
    $rose(rst_out_n_o) |-> $past(osc_rise));

  assert_count_bound_R3: assert property (@(posedge sys_clk) disable iff (hard_rst)
    (st == S_POR || st == S_WAKE) |-> (cnt < lim));

  assert_ce_at_fall_R6: assert property (@(posedge sys_clk) disable iff (hard_rst)
    per_ce_o |-> (!bus_clk_o && $past(bus_clk_o)));

  assert_core_needs_per_R7: assert property (@(posedge sys_clk) disable iff (hard_rst)
    cpu_ce_o |-> per_ce_o);

  assert_stop_parked_R9: assert property (@(posedge sys_clk) disable iff (hard_rst)
    (st == S_STOP && $past(st) == S_STOP) |-> (!bus_clk_o && !per_ce_o && rst_out_n_o));

  assert_sel_on_boundary_R11: assert property (@(posedge sys_clk) disable iff (hard_rst)
    (st == S_RUN && $past(st) == S_RUN && !$stable(sel_q)) |-> (phase == 2'd0));

endmodule

// File: tb/bus_clk_rst_seq_tb.sv
module bus_clk_rst_seq_tb;
  localparam int POR_N  = 4096;
  localparam int STOP_N = 4096;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic osc = 1'b0, pll = 1'b0, sel = 1'b0, por = 1'b1, lvr = 1'b0;
  logic stp = 1'b0, wt = 1'b0, wake = 1'b0;
  wire bus, cpu, per, rstn;
  int checks = 0, fails = 0;

  bus_clk_rst_seq #(.POR_CYCLES(POR_N), .STOP_CYCLES(STOP_N)) u_dut (
    .sys_clk(clk), .osc_clk_i(osc), .pll_clk_i(pll), .pll_sel_i(sel),
    .por_req_i(por), .lvr_req_i(lvr), .stop_req_i(stp), .wait_req_i(wt),
    .wake_irq_i(wake), .bus_clk_o(bus), .cpu_ce_o(cpu), .per_ce_o(per),
    .rst_out_n_o(rstn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(input bit s);
    return s ? 8 : 16;
  endfunction

  function automatic int exp_first_rise(input int l);
    return l + 2;
  endfunction

  int n = 0, cnt = 0, lim = POR_N;
  bit meas = 0, meas_d = 0, meas_done = 0, chk_por = 0;
  logic prev_rstn = 1'b0, prev_bus = 1'b0;

  always @(negedge clk) begin
    if (meas && !meas_done) begin
      if (chk_por && rstn === 1'b1 && prev_rstn === 1'b0) check(cnt == lim, "R3", cnt, lim);
      if (bus === 1'b1 && prev_bus === 1'b0) begin
        check(cnt == exp_first_rise(lim), chk_por ? "R5" : "R10", cnt, exp_first_rise(lim));
        meas_done = 1;
      end
    end
    if (!meas) meas_done = 0;
    prev_rstn = rstn;
    prev_bus = bus;
    n++;
    pll = n[0];
    osc = n[1];
    if (meas && !meas_d) cnt = 0;
    if (meas && n[1:0] == 2'b10) cnt++;
    meas_d = meas;
  end

  task automatic finish_tb();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic bus_rise(output int gap, output int c, output int p);
    logic last;
    gap = 0; c = 0; p = 0;
    last = bus;
    forever begin
      @(negedge clk);
      gap++;
      if (cpu === 1'b1) c++;
      if (per === 1'b1) p++;
      if (bus === 1'b1 && last === 1'b0) break;
      last = bus;
    end
  endtask

  task automatic release_meas(input bit is_por, input int l);
    lim = l; chk_por = is_por; meas = 1;
    wait (meas_done);
    @(posedge clk); #1;
    meas = 0; chk_por = 0;
  endtask

  task automatic pulse_wake();
    @(posedge clk); #1 wake = 1'b1;
    @(posedge clk); #1 wake = 1'b0;
  endtask

  task automatic enter_stop();
    int g, c, p;
    bus_rise(g, c, p);
    @(posedge clk); #1 stp = 1'b1;
    repeat (40) @(negedge clk);
    @(posedge clk); #1 stp = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "WATCHDOG", 0, 1);
    finish_tb();
  end

  initial begin
    int g, c, p, bad;
    bit s;
    void'($urandom(32'h5EED_0001));
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(rstn === 1'b0, "R2", int'(rstn), 0);
    check(bus === 1'b0, "R2", int'(bus), 0);
    check(cpu === 1'b0 && per === 1'b0, "R2", int'({cpu, per}), 0);

    @(posedge clk); #1 por = 1'b0;
    fork
      release_meas(1, POR_N);
      begin
        repeat (8000) @(negedge clk);
        check(rstn === 1'b0 && bus === 1'b0, "R3", int'({rstn, bus}), 0);
      end
    join

    bus_rise(g, c, p);
    bus_rise(g, c, p);
    check(g == exp_period(0), "R1", g, exp_period(0));
    check(c == 1 && p == 1, "R6", c * 10 + p, 11);

    bus_rise(g, c, p);
    @(posedge clk); #1 sel = 1'b1;
    bus_rise(g, c, p);
    check(g == 11, "R11", g, 11);
    bus_rise(g, c, p);
    check(g == exp_period(1), "R1", g, exp_period(1));

    for (int i = 0; i < 20; i++) begin
      s = 1'($urandom % 2);
      @(posedge clk); #1 sel = s;
      bus_rise(g, c, p);
      bus_rise(g, c, p);
      bus_rise(g, c, p);
      check(g == exp_period(s), "R1", g, exp_period(s));
      check(c == 1 && p == 1, "R6", c * 10 + p, 11);
      if ($urandom % 3 == 0) begin
        @(posedge clk); #1 wt = 1'b1;
        bus_rise(g, c, p);
        @(posedge clk); #1 wt = 1'b0;
        bus_rise(g, c, p);
        bus_rise(g, c, p);
        check(c == 0, "R7", c, 0);
        check(p == 1 && g == exp_period(s), "R7", g, exp_period(s));
        pulse_wake();
        bus_rise(g, c, p);
        check(c == 1, "R8", c, 1);
      end
    end

    @(posedge clk); #1 sel = 1'b0;
    bus_rise(g, c, p);
    bus_rise(g, c, p);

    enter_stop();
    bad = 0;
    repeat (200) @(negedge clk)
      if (bus !== 1'b0 || cpu !== 1'b0 || per !== 1'b0 || rstn !== 1'b1) bad++;
    check(bad == 0, "R9", bad, 0);

    pulse_wake();
    fork
      release_meas(0, STOP_N);
      begin
        repeat (8000) @(negedge clk);
        check(rstn === 1'b1 && bus === 1'b0, "R10", int'({rstn, bus}), 2);
      end
    join
    bus_rise(g, c, p);
    check(g == exp_period(0) && c == 1, "R10", g, exp_period(0));

    enter_stop();
    pulse_wake();
    repeat (3000) @(negedge clk);
    @(posedge clk); #1 lvr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(rstn === 1'b0, "R4", int'(rstn), 0);
    check(bus === 1'b0, "R2", int'(bus), 0);
    @(posedge clk); #1 lvr = 1'b0;
    release_meas(1, POR_N);

    @(posedge clk); #1 por = 1'b1;
    @(posedge clk); #1 por = 1'b0;
    repeat (5000) @(negedge clk);
    check(rstn === 1'b0, "R4", int'(rstn), 0);
    @(posedge clk); #1 por = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(rstn === 1'b0 && cpu === 1'b0, "R2", int'({rstn, cpu}), 0);
    @(posedge clk); #1 por = 1'b0;
    release_meas(1, POR_N);
    bus_rise(g, c, p);
    check(g == exp_period(0), "R4", g, exp_period(0));

    finish_tb();
  end
endmodule